// File: doc/BRIEF.md
# Masked Multi-Field Packet Address Matcher

This block decides whether a received packet carries an accepted destination address. After a packet has landed in a byte-addressable packet buffer, a controller pulses `start`. The block then walks a small configuration table that holds a chain of address fields. Each field is a length byte followed by that many pattern pairs, and each pair is a match byte and then its mask byte. The chain ends at a zero length byte. Each field is compared byte by byte against the packet, starting at the packet position given by `addr_pos`. Only the bits set in the mask take part.

Fields are tried in table order and the first field whose every byte agrees wins. The block pulses `done` and shows `match`, and `field_index` gives the 0-based number of the winning field. A zero first length turns matching off, and the packet is then accepted at once. A chain that runs past the end of the table is rejected.

Both storage sides are plain synchronous read ports with a fixed one-cycle latency. Data for an address presented with its enable in one cycle is used in the next cycle. These ports have no valid/ready flow control and no back-pressure: the block expects an answer every time, and the controller only sees `start`/`done`.

Top module: `pkt_addr_matcher`

## Requirements
- R1: The table starts with a length byte at configuration address 0x12A. A field of length N is followed by N pairs: the match byte of byte k sits at (length position + 1 + 2k) and its mask byte sits at (length position + 2 + 2k). The next field's length byte comes directly after the last mask byte.
- R2: Packet byte k agrees when ((packet byte XOR match byte) AND mask byte) is zero. A field hits only when all N of its bytes agree.
- R3: If the length byte at 0x12A is zero, the result is match=1 with field_index=0.
- R4: Fields are examined in table order and the first hit wins. field_index is the 0-based position of that field in the chain.
- R5: A zero length byte after at least one field ends the search with match=0 and field_index=0.
- R6: The last table address is 0x13D. A field whose last mask byte would lie beyond 0x13D ends the search with match=0. The same result follows when the length byte after a missed field would lie beyond 0x13D. No configuration read ever leaves 0x12A..0x13D.
- R7: done is a one-cycle pulse. It rises E clock edges after the edge that accepts start. E counts one edge for every length byte read and two edges for every byte compared.
- R8: match and field_index keep their values from one done pulse until the next.
- R9: start is ignored while a search is in progress.
- R10: During and right after reset, done, match, field_index, cfg_ren and pkt_ren are all 0.
- R11: Packet byte k of every field is read from packet address (addr_pos + k) modulo 256. The packet address wraps past 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; taken only when idle |
| addr_pos | input | 8 | Packet buffer position of the first address byte |
| cfg_ren | output | 1 | Configuration table read enable |
| cfg_raddr | output | 9 | Configuration table read address |
| cfg_rdata | input | 8 | Configuration data, one cycle after the read |
| pkt_ren | output | 1 | Packet buffer read enable |
| pkt_raddr | output | 8 | Packet buffer read address |
| pkt_rdata | input | 8 | Packet data, one cycle after the read |
| done | output | 1 | One-cycle pulse when the result is ready |
| match | output | 1 | Packet address accepted |
| field_index | output | 3 | 0-based index of the field that hit |

## Verification
The bound checker watches four rules on every cycle:
- done never lasts two cycles.
- The result outputs stay frozen between done pulses.
- A rejection always reports field index zero, and an accepted index stays within the number of fields the table can hold.
- Every configuration read stays inside the table window.

Only the bench's scenarios can show the rest:
- whether the masked comparison picks the right field;
- the behaviour when matching is disabled, on overflow and when the table is used up;
- packet address wrap;
- that start is ignored while a search runs;
- the exact number of cycles to done.

The bench covers these with directed tables and random field chains.

// File: rtl/pam_pkg.sv
`timescale 1ns/1ps
package pam_pkg;
  // search sequencer states
  typedef enum logic [1:0] {
    PAM_IDLE = 2'd0,  // waiting for start
    PAM_LEN  = 2'd1,  // length byte arriving
    PAM_MASK = 2'd2,  // match byte and packet byte arriving
    PAM_CMP  = 2'd3   // mask byte arriving, compare
  } pam_state_e;
endpackage

// File: rtl/pam_byte_lane.sv
`timescale 1ns/1ps
module pam_byte_lane #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] cfg_rdata,
  input  logic [DW-1:0] pkt_rdata,
  output logic          byte_ok
);
  logic [DW-1:0] pat_q;
  logic [DW-1:0] pkt_q;

  // hold the match byte and packet byte while the mask byte is fetched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      pkt_q <= '0;
    end else if (capture) begin
      pat_q <= cfg_rdata;
      pkt_q <= pkt_rdata;
    end
  end

  // mask byte is on cfg_rdata in the compare cycle
  always_comb begin
    byte_ok = (((pkt_q ^ pat_q) & cfg_rdata) == '0);
  end
endmodule

// File: rtl/pam_rd_addr.sv
`timescale 1ns/1ps
module pam_rd_addr
  import pam_pkg::*;
#(
  parameter int CFG_AW    = 9,
  parameter int PKT_AW    = 8,
  parameter int DW        = 8,
  parameter int TBL_FIRST = 'h12A,
  parameter int TBL_LAST  = 'h13D
) (
  input  pam_state_e        state,
  input  logic              start,
  input  logic [CFG_AW-1:0] ptr,
  input  logic [DW-1:0]     bidx,
  input  logic [PKT_AW-1:0] base_pos,
  output logic              cfg_ren,
  output logic [CFG_AW-1:0] cfg_raddr,
  output logic              pkt_ren,
  output logic [PKT_AW-1:0] pkt_raddr
);
  localparam logic [CFG_AW:0]   LAST_X  = (CFG_AW+1)'(TBL_LAST);
  localparam logic [CFG_AW-1:0] FIRST_A = CFG_AW'(TBL_FIRST);

  logic [CFG_AW:0]   ptr_p1;
  logic [CFG_AW:0]   ptr_p2;
  logic [PKT_AW-1:0] pkt_k;

  always_comb begin
    ptr_p1 = {1'b0, ptr} + (CFG_AW+1)'(1);
    ptr_p2 = {1'b0, ptr} + (CFG_AW+1)'(2);
    pkt_k  = base_pos + PKT_AW'(bidx);
  end

  always_comb begin
    cfg_ren   = 1'b0;
    cfg_raddr = FIRST_A;
    pkt_ren   = 1'b0;
    pkt_raddr = pkt_k;
    unique case (state)
      PAM_IDLE: begin
        cfg_ren   = start;
        cfg_raddr = FIRST_A;
      end
      PAM_LEN: begin
        // first match byte of the field and first packet byte
        cfg_ren   = (ptr_p1 <= LAST_X);
        cfg_raddr = ptr_p1[CFG_AW-1:0];
        pkt_ren   = 1'b1;
        pkt_raddr = base_pos;
      end
      PAM_MASK: begin
        cfg_ren   = 1'b1;
        cfg_raddr = ptr_p1[CFG_AW-1:0];
      end
      PAM_CMP: begin
        // next match byte, or the next length byte
        cfg_ren   = (ptr_p2 <= LAST_X);
        cfg_raddr = ptr_p2[CFG_AW-1:0];
        pkt_ren   = 1'b1;
        pkt_raddr = pkt_k + PKT_AW'(1);
      end
      default: begin
        cfg_ren = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pam_seq.sv
`timescale 1ns/1ps
module pam_seq
  import pam_pkg::*;
#(
  parameter int CFG_AW    = 9,
  parameter int DW        = 8,
  parameter int TBL_FIRST = 'h12A,
  parameter int TBL_LAST  = 'h13D,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DW-1:0]     cfg_rdata,
  input  logic              byte_ok,
  output pam_state_e        state,
  output logic [CFG_AW-1:0] ptr,
  output logic [DW-1:0]     bidx,
  output logic              done,
  output logic              match,
  output logic [IDX_W-1:0]  field_index
);
  // wide enough for a table address plus twice a length byte
  localparam int SPAN_W = ((CFG_AW > DW + 1) ? CFG_AW : DW + 1) + 1;
  localparam logic [SPAN_W-1:0] LAST_S = SPAN_W'(TBL_LAST);

  pam_state_e        state_q;
  logic [CFG_AW-1:0] ptr_q;
  logic [DW-1:0]     len_q;
  logic [DW-1:0]     bidx_q;
  logic [IDX_W-1:0]  fidx_q;
  logic              acc_q;
  logic              done_q;
  logic              match_q;
  logic [IDX_W-1:0]  idx_q;

  logic [SPAN_W-1:0] field_end;
  logic [SPAN_W-1:0] next_len_pos;
  logic              acc_n;
  logic              last_byte;

  always_comb begin
    field_end    = SPAN_W'(ptr_q) + SPAN_W'({cfg_rdata, 1'b0});
    next_len_pos = SPAN_W'(ptr_q) + SPAN_W'(2);
    acc_n        = acc_q & byte_ok;
    last_byte    = (bidx_q == (len_q - DW'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PAM_IDLE;
      ptr_q   <= '0;
      len_q   <= '0;
      bidx_q  <= '0;
      fidx_q  <= '0;
      acc_q   <= 1'b0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PAM_IDLE: begin
          if (start) begin
            ptr_q   <= CFG_AW'(TBL_FIRST);
            fidx_q  <= '0;
            state_q <= PAM_LEN;
          end
        end
        PAM_LEN: begin
          len_q  <= cfg_rdata;
          bidx_q <= '0;
          acc_q  <= 1'b1;
          if (cfg_rdata == '0) begin
            // end of chain; an empty chain disables filtering
            done_q  <= 1'b1;
            match_q <= (fidx_q == '0);
            idx_q   <= '0;
            state_q <= PAM_IDLE;
          end else if (field_end > LAST_S) begin
            done_q  <= 1'b1;
            match_q <= 1'b0;
            idx_q   <= '0;
            state_q <= PAM_IDLE;
          end else begin
            ptr_q   <= ptr_q + CFG_AW'(1);
            state_q <= PAM_MASK;
          end
        end
        PAM_MASK: begin
          state_q <= PAM_CMP;
        end
        PAM_CMP: begin
          if (last_byte) begin
            if (acc_n) begin
              done_q  <= 1'b1;
              match_q <= 1'b1;
              idx_q   <= fidx_q;
              state_q <= PAM_IDLE;
            end else if (next_len_pos > LAST_S) begin
              done_q  <= 1'b1;
              match_q <= 1'b0;
              idx_q   <= '0;
              state_q <= PAM_IDLE;
            end else begin
              ptr_q   <= ptr_q + CFG_AW'(2);
              fidx_q  <= fidx_q + IDX_W'(1);
              state_q <= PAM_LEN;
            end
          end else begin
            bidx_q  <= bidx_q + DW'(1);
            ptr_q   <= ptr_q + CFG_AW'(2);
            acc_q   <= acc_n;
            state_q <= PAM_MASK;
          end
        end
        default: state_q <= PAM_IDLE;
      endcase
    end
  end

  assign state       = state_q;
  assign ptr         = ptr_q;
  assign bidx        = bidx_q;
  assign done        = done_q;
  assign match       = match_q;
  assign field_index = idx_q;
endmodule

// File: rtl/pkt_addr_matcher.sv
`timescale 1ns/1ps
module pkt_addr_matcher
  import pam_pkg::*;
#(
  parameter int CFG_AW    = 9,
  parameter int PKT_AW    = 8,
  parameter int DW        = 8,
  parameter int TBL_FIRST = 'h12A,
  parameter int TBL_LAST  = 'h13D,
  parameter int IDX_W     = $clog2((TBL_LAST - TBL_FIRST + 1) / 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PKT_AW-1:0] addr_pos,
  output logic              cfg_ren,
  output logic [CFG_AW-1:0] cfg_raddr,
  input  logic [DW-1:0]     cfg_rdata,
  output logic              pkt_ren,
  output logic [PKT_AW-1:0] pkt_raddr,
  input  logic [DW-1:0]     pkt_rdata,
  output logic              done,
  output logic              match,
  output logic [IDX_W-1:0]  field_index
);
  pam_state_e        state;
  logic [CFG_AW-1:0] ptr;
  logic [DW-1:0]     bidx;
  logic              byte_ok;
  logic              capture;

  assign capture = (state == PAM_MASK);

  pam_seq #(
    .CFG_AW(CFG_AW), .DW(DW), .TBL_FIRST(TBL_FIRST),
    .TBL_LAST(TBL_LAST), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_rdata(cfg_rdata),
    .byte_ok(byte_ok), .state(state), .ptr(ptr), .bidx(bidx),
    .done(done), .match(match), .field_index(field_index)
  );

  pam_rd_addr #(
    .CFG_AW(CFG_AW), .PKT_AW(PKT_AW), .DW(DW),
    .TBL_FIRST(TBL_FIRST), .TBL_LAST(TBL_LAST)
  ) u_addr (
    .state(state), .start(start), .ptr(ptr), .bidx(bidx),
    .base_pos(addr_pos), .cfg_ren(cfg_ren), .cfg_raddr(cfg_raddr),
    .pkt_ren(pkt_ren), .pkt_raddr(pkt_raddr)
  );

  pam_byte_lane #(.DW(DW)) u_lane (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .cfg_rdata(cfg_rdata), .pkt_rdata(pkt_rdata), .byte_ok(byte_ok)
  );
endmodule

// File: rtl/pam_checker.sv
`timescale 1ns/1ps
module pam_checker #(
  parameter int CFG_AW    = 9,
  parameter int TBL_FIRST = 'h12A,
  parameter int TBL_LAST  = 'h13D,
  parameter int IDX_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ren,
  input logic [CFG_AW-1:0] cfg_raddr,
  input logic              done,
  input logic              match,
  input logic [IDX_W-1:0]  field_index
);
  localparam int MAX_FIELDS = (TBL_LAST - TBL_FIRST + 1) / 3;
  localparam logic [CFG_AW-1:0] FIRST_A = CFG_AW'(TBL_FIRST);
  localparam logic [CFG_AW-1:0] LAST_A  = CFG_AW'(TBL_LAST);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(match) && $stable(field_index)));

  a_r5_reject_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !match) |-> (field_index == '0));

  a_r4_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && match) |-> (int'(field_index) < MAX_FIELDS));

  a_r6_cfg_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ren |-> ((cfg_raddr >= FIRST_A) && (cfg_raddr <= LAST_A)));
endmodule

bind pkt_addr_matcher pam_checker #(
  .CFG_AW(CFG_AW), .TBL_FIRST(TBL_FIRST), .TBL_LAST(TBL_LAST), .IDX_W(IDX_W)
) u_pam_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ren(cfg_ren), .cfg_raddr(cfg_raddr),
  .done(done), .match(match), .field_index(field_index)
);

// File: tb/pkt_addr_matcher_tb_top.sv
`timescale 1ns/1ps
module pkt_addr_matcher_tb_top;
  localparam int CFG_AW = 9;
  localparam int PKT_AW = 8;
  localparam int FIRST  = 'h12A;
  localparam int LAST   = 'h13D;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] addr_pos = '0;
  logic cfg_ren, pkt_ren, done, match;
  logic [CFG_AW-1:0] cfg_raddr;
  logic [PKT_AW-1:0] pkt_raddr;
  logic [7:0] cfg_rdata = '0;
  logic [7:0] pkt_rdata = '0;
  logic [IDX_W-1:0] field_index;

  logic [7:0] cfg_mem [0:511];
  logic [7:0] pkt_mem [0:255];

  int total = 0;
  int bad = 0;
  bit oob_seen = 1'b0;
  logic [7:0] rand_off;

  always #10 clk = ~clk;

  pkt_addr_matcher #(
    .CFG_AW(CFG_AW), .PKT_AW(PKT_AW), .DW(8),
    .TBL_FIRST(FIRST), .TBL_LAST(LAST), .IDX_W(IDX_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_pos(addr_pos),
    .cfg_ren(cfg_ren), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .pkt_ren(pkt_ren), .pkt_raddr(pkt_raddr), .pkt_rdata(pkt_rdata),
    .done(done), .match(match), .field_index(field_index)
  );

  // one-cycle read latency storage models
  always_ff @(posedge clk) begin
    if (cfg_ren) cfg_rdata <= cfg_mem[cfg_raddr];
    if (pkt_ren) pkt_rdata <= pkt_mem[pkt_raddr];
  end

  always @(negedge clk)
    if (rst_n && cfg_ren && ((int'(cfg_raddr) < FIRST) || (int'(cfg_raddr) > LAST)))
      oob_seen = 1'b1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference search computed from the table rules
  task automatic ref_eval(input logic [7:0] off, output bit m, output int idx, output int lat);
    int p;
    int f;
    p = FIRST; f = 0; lat = 0; m = 1'b0; idx = 0;
    while (1) begin
      int n;
      bit hit;
      lat++;
      n = int'(cfg_mem[p]);
      if (n == 0) begin m = (f == 0); return; end
      if (p + 2 * n > LAST) return;
      hit = 1'b1;
      for (int k = 0; k < n; k++) begin
        logic [7:0] pb;
        pb = pkt_mem[8'(int'(off) + k)];
        if (((pb ^ cfg_mem[p + 1 + 2 * k]) & cfg_mem[p + 2 + 2 * k]) != 8'h00) hit = 1'b0;
      end
      lat += 2 * n;
      if (hit) begin m = 1'b1; idx = f; return; end
      if (p + 2 * n + 1 > LAST) return;
      p += 2 * n + 1;
      f++;
    end
  endtask

  task automatic run_one(input string req, input logic [7:0] off, input bit hold);
    bit em;
    int ei;
    int el;
    int cnt;
    bit got;
    ref_eval(off, em, ei, el);
    @(negedge clk);
    addr_pos = off;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!hold) start = 1'b0;
    cnt = 0;
    got = 1'b0;
    while (!got && cnt < 1000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (done) got = 1'b1;
    end
    start = 1'b0;
    chk("R7", "done seen", int'(got), 1);
    chk("R7", "latency", cnt, el);
    chk(req, "match", int'(match), int'(em));
    chk(req, "field_index", int'(field_index), ei);
    @(negedge clk);
    chk("R7", "done pulse width", int'(done), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R8", "match held", int'(match), int'(em));
    chk("R8", "index held", int'(field_index), ei);
  endtask

  task automatic clr_tbl();
    for (int a = 'h120; a < 'h150; a++) cfg_mem[a] = 8'hA5;
    for (int a = 0; a < 256; a++) pkt_mem[a] = 8'h5A;
  endtask

  task automatic gen_random();
    int p;
    int nf;
    int cnt;
    int fp [4];
    int fl [4];
    for (int a = FIRST; a <= LAST; a++) cfg_mem[a] = 8'($urandom);
    for (int a = 0; a < 256; a++) pkt_mem[a] = 8'($urandom);
    p = FIRST;
    cnt = 0;
    nf = 1 + int'($urandom % 4);
    for (int i = 0; i < nf; i++) begin
      int n;
      n = 1 + int'($urandom % 3);
      if (p + 2 * n > LAST) break;
      cfg_mem[p] = 8'(n);
      for (int k = 0; k < n; k++) begin
        cfg_mem[p + 1 + 2 * k] = 8'($urandom);
        cfg_mem[p + 2 + 2 * k] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      end
      fp[cnt] = p;
      fl[cnt] = n;
      cnt++;
      p += 2 * n + 1;
    end
    if (p <= LAST && ($urandom % 5) != 0) cfg_mem[p] = 8'h00;
    if ($urandom % 10 == 0) cfg_mem[FIRST] = 8'h00;
    rand_off = 8'($urandom);
    if (cnt > 0 && ($urandom % 2) == 0) begin
      int j;
      j = int'($urandom % cnt);
      for (int k = 0; k < fl[j]; k++) begin
        logic [7:0] mb;
        logic [7:0] kb;
        mb = cfg_mem[fp[j] + 1 + 2 * k];
        kb = cfg_mem[fp[j] + 2 + 2 * k];
        pkt_mem[8'(int'(rand_off) + k)] = (mb & kb) | (8'($urandom) & ~kb);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int a = 0; a < 512; a++) cfg_mem[a] = 8'h00;
    clr_tbl();
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10", "done", int'(done), 0);
    chk("R10", "match", int'(match), 0);
    chk("R10", "field_index", int'(field_index), 0);
    chk("R10", "cfg_ren", int'(cfg_ren), 0);
    chk("R10", "pkt_ren", int'(pkt_ren), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: empty chain accepts
    clr_tbl();
    cfg_mem['h12A] = 8'h00;
    run_one("R3", 8'h10, 1'b0);

    // R2: masked compare, low nibble of byte 1 ignored
    clr_tbl();
    cfg_mem['h12A] = 8'd2;
    cfg_mem['h12B] = 8'h3C; cfg_mem['h12C] = 8'hFF;
    cfg_mem['h12D] = 8'h81; cfg_mem['h12E] = 8'hF0;
    cfg_mem['h12F] = 8'h00;
    pkt_mem[8'h10] = 8'h3C; pkt_mem[8'h11] = 8'h8E;
    run_one("R2", 8'h10, 1'b0);
    // R5: masked-in bit differs, chain ends with no hit
    pkt_mem[8'h11] = 8'h9E;
    run_one("R5", 8'h10, 1'b0);

    // R4: fields 1 and 2 both hit, first wins
    clr_tbl();
    cfg_mem['h12A] = 8'd1; cfg_mem['h12B] = 8'h11; cfg_mem['h12C] = 8'hFF;
    cfg_mem['h12D] = 8'd1; cfg_mem['h12E] = 8'h22; cfg_mem['h12F] = 8'hFF;
    cfg_mem['h130] = 8'd1; cfg_mem['h131] = 8'h22; cfg_mem['h132] = 8'h0F;
    cfg_mem['h133] = 8'h00;
    pkt_mem[8'h40] = 8'h22;
    run_one("R4", 8'h40, 1'b0);
    // R9: start held high through the search changes nothing
    run_one("R9", 8'h40, 1'b1);

    // R6: field too long for the table
    clr_tbl();
    cfg_mem['h12A] = 8'd10;
    run_one("R6", 8'h00, 1'b0);

    // R6: table used up exactly, no terminator possible
    clr_tbl();
    cfg_mem['h12A] = 8'd4;
    for (int k = 0; k < 4; k++) begin
      cfg_mem['h12B + 2 * k] = 8'h00; cfg_mem['h12C + 2 * k] = 8'hFF;
    end
    cfg_mem['h133] = 8'd5;
    for (int k = 0; k < 5; k++) begin
      cfg_mem['h134 + 2 * k] = 8'h00; cfg_mem['h135 + 2 * k] = 8'hFF;
    end
    run_one("R6", 8'h20, 1'b0);

    // R11: packet address wraps
    clr_tbl();
    cfg_mem['h12A] = 8'd3;
    cfg_mem['h12B] = 8'hA1; cfg_mem['h12C] = 8'hFF;
    cfg_mem['h12D] = 8'hB2; cfg_mem['h12E] = 8'hFF;
    cfg_mem['h12F] = 8'hC3; cfg_mem['h130] = 8'hFF;
    cfg_mem['h131] = 8'h00;
    pkt_mem[8'hFE] = 8'hA1; pkt_mem[8'hFF] = 8'hB2; pkt_mem[8'h00] = 8'hC3;
    run_one("R11", 8'hFE, 1'b0);

    // R1: random field chains
    for (int i = 0; i < 40; i++) begin
      gen_random();
      run_one("R1", rand_off, ($urandom % 4) == 0);
    end

    chk("R6", "out-of-table read", int'(oob_seen), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule